// File: doc/BRIEF.md
# Keyed-Header Serial Configuration Port

This block loads the working parameters of a protection channel (four trip thresholds and three filter coefficients) over a bit-serial link. No character framing is used. A frame-select line brackets each packet. Data bits are taken on rising edges of a serial clock. Both lines are resynchronised into the system clock domain. A packet has a fixed 16-bit key header, a 4-bit register address, a 32-bit value and an 8-bit CRC. The value reaches a working register only when the header matches, the CRC checks and the address names a real register. Any rejected packet is dropped without effect and sets a sticky error flag. The next accepted packet clears that flag.

A separate serial transmitter returns the contents of one register, so the external computer can confirm what was loaded. It can also return the live filter input sample or the live filter output sample. Each readback frame carries 32 data bits followed by an 8-bit CRC, computed the same way as on receive.

The receiver state machine has four states:
- RX_IDLE: waits for the frame select. It moves to RX_SHIFT when select rises.
- RX_SHIFT: collects bits. It returns to RX_IDLE if select drops early. It moves to RX_CHECK on the 60th bit.
- RX_CHECK: a single cycle that commits the packet or rejects it. It then moves to RX_DRAIN.
- RX_DRAIN: ignores further bits and returns to RX_IDLE when select drops.

The transmitter state machine has three states:
- TX_IDLE: moves to TX_DATA on a request.
- TX_DATA: sends 32 bits, then moves to TX_CRC.
- TX_CRC: sends 8 bits, then returns to TX_IDLE.

Top module: `cfgrx_port`

## Requirements
- R1: After reset, all seven working registers read zero, the error flag is low, and the transmitter is idle with `tx_active` and `tx_sdo` low.
- R2: While `rx_sel` is high, bits on `rx_sdi` are taken on rising edges of `rx_sclk`, MSB first. A packet is 60 bits: header [59:44], address [43:40], data [39:8], CRC [7:0]. An accepted packet writes its data to working register `address`, which appears on `cfg_regs[address*32 +: 32]`.
- R3: The CRC is CRC-8, polynomial 0x07, initial value 0, computed over bits [59:8] MSB first. On a mismatch the packet is discarded and `err_flag` is set.
- R4: A header different from parameter `KEY` (default 16'hA5C3) discards the packet and sets `err_flag`.
- R5: An address of 7 or more discards the packet and sets `err_flag`.
- R6: An accepted packet clears `err_flag`.
- R7: If `rx_sel` falls before 60 bits have arrived, the packet is dropped and neither the registers nor `err_flag` change.
- R8: Bits after the 60th are ignored until `rx_sel` falls.
- R9: The working registers change only in the single commit cycle of an accepted packet, and only the addressed register changes.
- R10: A one-cycle `rb_req` pulse, given while idle, latches a word selected by `rb_addr`: 0 to 6 select a working register, 7 selects `x_live`, 8 selects `y_live`, and any other value gives zero. The word goes out on `tx_sdo`, MSB first, each bit lasting `TX_DIV` clocks, followed by its CRC-8 (as in R3, but over the 32 data bits). `tx_active` stays high for all 40 bits.
- R11: An `rb_req` that arrives while a readback is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| rx_sdi | input | 1 | Serial data in |
| rx_sel | input | 1 | Frame select; high during a packet |
| x_live | input | 32 | Current filter input sample |
| y_live | input | 32 | Current filter output sample |
| rb_req | input | 1 | Readback request pulse |
| rb_addr | input | 4 | Readback selector |
| cfg_regs | output | 224 | Working registers, register i at bits [i*32 +: 32] |
| err_flag | output | 1 | Sticky rejected-packet flag |
| tx_sdo | output | 1 | Readback serial data |
| tx_active | output | 1 | High while a readback frame is being sent |

## Verification
The assertions check several rules on every cycle:
- The register bank stays unchanged outside a commit, and a commit always names a real register.
- A rejection always sets the error flag and a commit always clears it; with neither, the flag holds.
- The readback line stays low while idle.

Only the bench scenarios can show that the right bit patterns are accepted or rejected:
- a corrupted CRC, a wrong header and out-of-range addresses;
- truncated and over-long frames;
- readback frames that carry the right word and CRC, with a second request ignored while a frame is in progress.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
    localparam int HDR_W    = 16;
    localparam int ADR_W    = 4;
    localparam int DAT_W    = 32;
    localparam int CRC_W    = 8;
    localparam int PKT_W    = HDR_W + ADR_W + DAT_W + CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [1:0] {RX_IDLE, RX_SHIFT, RX_CHECK, RX_DRAIN} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_CRC} tx_state_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdi_in,
    input  logic sel_in,
    output logic bit_stb,
    output logic bit_val,
    output logic sel_lvl
);
    logic [2:0] sclk_q;
    logic [1:0] sdi_q;
    logic [1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            sdi_q  <= '0;
            sel_q  <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk_in};
            sdi_q  <= {sdi_q[0], sdi_in};
            sel_q  <= {sel_q[0], sel_in};
        end
    end

    assign bit_stb = sclk_q[1] & ~sclk_q[2];
    assign bit_val = sdi_q[1];
    assign sel_lvl = sel_q[1];
endmodule

// File: rtl/cfgrx_rx_fsm.sv
module cfgrx_rx_fsm
    import cfgrx_pkg::*;
#(
    parameter logic [HDR_W-1:0] KEY      = 16'hA5C3,
    parameter int               NUM_REGS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             sel_lvl,
    output logic             wr_en,
    output logic [ADR_W-1:0] wr_addr,
    output logic [DAT_W-1:0] wr_data,
    output logic             pkt_bad
);
    localparam int CNT_W = $clog2(PKT_W + 1);

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PKT_W-1:0] sh_q;
    logic [CRC_W-1:0] crc_q;
    logic             last_bit;
    logic             hdr_ok, crc_ok, adr_ok;

    assign last_bit = bit_stb && (cnt_q == CNT_W'(PKT_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (sel_lvl) state_d = RX_SHIFT;
            RX_SHIFT: begin
                if (!sel_lvl)      state_d = RX_IDLE;
                else if (last_bit) state_d = RX_CHECK;
            end
            RX_CHECK: state_d = RX_DRAIN;
            RX_DRAIN: if (!sel_lvl) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            crc_q <= '0;
        end else if (state_q == RX_IDLE) begin
            cnt_q <= '0;
            crc_q <= '0;
        end else if (state_q == RX_SHIFT && sel_lvl && bit_stb) begin
            sh_q  <= {sh_q[PKT_W-2:0], bit_val};
            crc_q <= crc_step(crc_q, bit_val);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wr_addr = sh_q[PKT_W-HDR_W-1 -: ADR_W];
    assign wr_data = sh_q[CRC_W +: DAT_W];

    always_comb begin
        hdr_ok  = (sh_q[PKT_W-1 -: HDR_W] == KEY);
        crc_ok  = (crc_q == '0);
        adr_ok  = (int'(wr_addr) < NUM_REGS);
        wr_en   = (state_q == RX_CHECK) &&  (hdr_ok && crc_ok && adr_ok);
        pkt_bad = (state_q == RX_CHECK) && !(hdr_ok && crc_ok && adr_ok);
    end
endmodule

// File: rtl/cfgrx_bank.sv
module cfgrx_bank
    import cfgrx_pkg::*;
#(
    parameter int NUM_REGS = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADR_W-1:0]          wr_addr,
    input  logic [DAT_W-1:0]          wr_data,
    input  logic                      pkt_bad,
    input  logic [ADR_W-1:0]          rd_addr,
    input  logic [DAT_W-1:0]          x_live,
    input  logic [DAT_W-1:0]          y_live,
    output logic [DAT_W-1:0]          rd_word,
    output logic [NUM_REGS*DAT_W-1:0] cfg_flat,
    output logic                      err_flag
);
    logic [DAT_W-1:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    regs_q[i] <= '0;
            else if (wr_en && wr_addr == ADR_W'(i))        regs_q[i] <= wr_data;
        end
        assign cfg_flat[i*DAT_W +: DAT_W] = regs_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (wr_en)   err_flag <= 1'b0;
        else if (pkt_bad) err_flag <= 1'b1;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADR_W'(i)) rd_word = regs_q[i];
        if (rd_addr == ADR_W'(NUM_REGS))     rd_word = x_live;
        if (rd_addr == ADR_W'(NUM_REGS + 1)) rd_word = y_live;
    end
endmodule

// File: rtl/cfgrx_tx.sv
module cfgrx_tx
    import cfgrx_pkg::*;
#(
    parameter int TX_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rb_req,
    input  logic [DAT_W-1:0] rd_word,
    output logic             tx_sdo,
    output logic             tx_active
);
    localparam int DIV_W = (TX_DIV > 1) ? $clog2(TX_DIV) : 1;
    localparam int BIT_W = $clog2(DAT_W + 1);

    tx_state_t        state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] bit_q;
    logic [DAT_W-1:0] sh_q;
    logic [CRC_W-1:0] crc_q;
    logic             tick, data_end, crc_end;
    logic [CRC_W-1:0] crc_nx;

    assign tick     = (div_q == DIV_W'(TX_DIV - 1));
    assign data_end = tick && (bit_q == BIT_W'(DAT_W - 1));
    assign crc_end  = tick && (bit_q == BIT_W'(CRC_W - 1));
    assign crc_nx   = crc_step(crc_q, sh_q[DAT_W-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (rb_req)   state_d = TX_DATA;
            TX_DATA: if (data_end) state_d = TX_CRC;
            TX_CRC:  if (crc_end)  state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
            crc_q <= '0;
        end else if (state_q == TX_IDLE) begin
            div_q <= '0;
            bit_q <= '0;
            crc_q <= '0;
            if (rb_req) sh_q <= rd_word;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                sh_q  <= {sh_q[DAT_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
                if (state_q == TX_DATA) crc_q <= crc_nx;
                if (data_end) begin
                    bit_q <= '0;
                    sh_q  <= {crc_nx, {(DAT_W-CRC_W){1'b0}}};
                end
            end
        end
    end

    always_comb begin
        tx_active = (state_q != TX_IDLE);
        tx_sdo    = tx_active & sh_q[DAT_W-1];
    end
endmodule

// File: rtl/cfgrx_port.sv
module cfgrx_port
    import cfgrx_pkg::*;
#(
    parameter logic [15:0] KEY      = 16'hA5C3,
    parameter int          NUM_REGS = 7,
    parameter int          TX_DIV   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_sclk,
    input  logic                      rx_sdi,
    input  logic                      rx_sel,
    input  logic [31:0]               x_live,
    input  logic [31:0]               y_live,
    input  logic                      rb_req,
    input  logic [3:0]                rb_addr,
    output logic [NUM_REGS*32-1:0]    cfg_regs,
    output logic                      err_flag,
    output logic                      tx_sdo,
    output logic                      tx_active
);
    logic             bit_stb, bit_val, sel_lvl;
    logic             wr_en, pkt_bad;
    logic [ADR_W-1:0] wr_addr;
    logic [DAT_W-1:0] wr_data, rd_word;

    cfgrx_sync u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_in(rx_sclk), .sdi_in(rx_sdi), .sel_in(rx_sel),
        .bit_stb(bit_stb), .bit_val(bit_val), .sel_lvl(sel_lvl)
    );

    cfgrx_rx_fsm #(.KEY(KEY), .NUM_REGS(NUM_REGS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .bit_stb(bit_stb), .bit_val(bit_val), .sel_lvl(sel_lvl),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pkt_bad(pkt_bad)
    );

    cfgrx_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pkt_bad(pkt_bad),
        .rd_addr(rb_addr), .x_live(x_live), .y_live(y_live),
        .rd_word(rd_word), .cfg_flat(cfg_regs), .err_flag(err_flag)
    );

    cfgrx_tx #(.TX_DIV(TX_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .rb_req(rb_req), .rd_word(rd_word),
        .tx_sdo(tx_sdo), .tx_active(tx_active)
    );
endmodule

// File: rtl/cfgrx_port_chk.sv
module cfgrx_port_chk #(
    parameter int NUM_REGS = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   pkt_bad,
    input logic [3:0]             wr_addr,
    input logic [NUM_REGS*32-1:0] cfg_regs,
    input logic                   err_flag,
    input logic                   tx_sdo,
    input logic                   tx_active
);
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NUM_REGS));

    // covers R3 and R4 as well: every rejection sets the flag
    p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_bad |=> err_flag);

    p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !err_flag);

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !pkt_bad) |=> $stable(err_flag));

    p_idle_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !tx_sdo);
endmodule

bind cfgrx_port cfgrx_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pkt_bad(pkt_bad),
    .wr_addr(wr_addr), .cfg_regs(cfg_regs), .err_flag(err_flag),
    .tx_sdo(tx_sdo), .tx_active(tx_active)
);

// File: tb/test_cfgrx_port.sv
module test_cfgrx_port;
    localparam int NREG   = 7;
    localparam int TXDIV  = 4;
    localparam logic [15:0] KEYV = 16'hA5C3;

    logic clk = 0, rst_n = 0;
    logic rx_sclk = 0, rx_sdi = 0, rx_sel = 0;
    logic [31:0] x_live = 32'h1234_5678, y_live = 32'h9ABC_DEF0;
    logic rb_req = 0;
    logic [3:0] rb_addr = 0;
    logic [NREG*32-1:0] cfg_regs;
    logic err_flag, tx_sdo, tx_active;

    int checks = 0, errors = 0;
    logic [31:0] mdl [NREG];
    logic        err_m;
    logic [39:0] expq [$];
    bit          done = 0;

    always #2 clk = ~clk;

    cfgrx_port #(.KEY(KEYV), .NUM_REGS(NREG), .TX_DIV(TXDIV)) i_cfgrx_port (
        .clk(clk), .rst_n(rst_n), .rx_sclk(rx_sclk), .rx_sdi(rx_sdi), .rx_sel(rx_sel),
        .x_live(x_live), .y_live(y_live), .rb_req(rb_req), .rb_addr(rb_addr),
        .cfg_regs(cfg_regs), .err_flag(err_flag), .tx_sdo(tx_sdo), .tx_active(tx_active)
    );

    function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
        logic [7:0] c = 8'h00;
        for (int i = n - 1; i >= 0; i--) begin
            logic msb = c[7];
            c = c << 1;
            if (msb != v[i]) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < NREG; i++) chk(req, cfg_regs[i*32 +: 32], mdl[i]);
        chk(req, err_flag, err_m);
    endtask

    // nbits bits of the packet, then garbage if nbits > 60
    task automatic send(input logic [15:0] hdr, input logic [3:0] adr, input logic [31:0] dat,
                        input logic [7:0] crc_xor, input int nbits);
        logic [59:0] pkt;
        pkt = {hdr, adr, dat, 8'h00};
        pkt[7:0] = ref_crc({12'h0, pkt[59:8]}, 52) ^ crc_xor;
        @(negedge clk); rx_sel = 1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rx_sdi = (i < 60) ? pkt[59 - i] : i[0];
            repeat (4) @(negedge clk); rx_sclk = 1;
            repeat (4) @(negedge clk); rx_sclk = 0;
        end
        repeat (4) @(negedge clk); rx_sel = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic readback(input logic [3:0] a, input logic [31:0] word, input bit extra);
        expq.push_back({word, ref_crc({32'h0, word}, 32)});
        @(negedge clk); rb_addr = a; rb_req = 1;
        @(negedge clk); rb_req = 0;
        if (extra) begin
            repeat (20) @(negedge clk);
            rb_addr = 4'd8; rb_req = 1;     // R11: must be ignored
            @(negedge clk); rb_req = 0;
        end
        while (!tx_active) @(negedge clk);
        while (tx_active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: collect each readback frame and compare with the scoreboard
    initial begin
        logic [39:0] fr;
        forever begin
            @(negedge clk);
            if (tx_active) begin
                fr[39] = tx_sdo;
                for (int k = 1; k < 40; k++) begin
                    repeat (TXDIV) @(negedge clk);
                    fr[39 - k] = tx_sdo;
                end
                if (expq.size() == 0) chk("R11 unexpected frame", fr, 40'h0);
                else chk("R10 readback frame", fr, expq.pop_front());
                while (tx_active) @(negedge clk);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        err_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_bank("R1 reset");
        chk("R1 tx idle", {tx_active, tx_sdo}, 2'b00);

        // R2: good writes, R9: only addressed register changes
        send(KEYV, 4'd0, 32'hDEAD_BEEF, 8'h00, 60); mdl[0] = 32'hDEAD_BEEF; chk_bank("R2 write reg0");
        send(KEYV, 4'd6, 32'h0000_0001, 8'h00, 60); mdl[6] = 32'h0000_0001; chk_bank("R2 write reg6");
        send(KEYV, 4'd3, 32'h8000_00FF, 8'h00, 60); mdl[3] = 32'h8000_00FF; chk_bank("R9 write reg3 only");

        // R3: corrupted CRC
        send(KEYV, 4'd1, 32'h1111_1111, 8'h01, 60); err_m = 1; chk_bank("R3 bad crc");
        // R6: good packet clears flag
        send(KEYV, 4'd1, 32'h2222_2222, 8'h00, 60); mdl[1] = 32'h2222_2222; err_m = 0; chk_bank("R6 clear err");
        // R4: wrong header
        send(16'hA5C2, 4'd2, 32'h3333_3333, 8'h00, 60); err_m = 1; chk_bank("R4 bad header");
        send(KEYV, 4'd2, 32'h4444_4444, 8'h00, 60); mdl[2] = 32'h4444_4444; err_m = 0; chk_bank("R6 clear err again");
        // R5: out-of-range addresses
        send(KEYV, 4'd7, 32'h5555_5555, 8'h00, 60); err_m = 1; chk_bank("R5 addr 7");
        send(KEYV, 4'd15, 32'h6666_6666, 8'h00, 60); chk_bank("R5 addr 15");
        // R7: truncated frames leave regs and flag alone
        send(KEYV, 4'd4, 32'h7777_7777, 8'h00, 59); chk_bank("R7 truncated flag kept");
        send(KEYV, 4'd5, 32'h8888_8888, 8'h00, 60); mdl[5] = 32'h8888_8888; err_m = 0; chk_bank("R2 write reg5");
        send(16'h0000, 4'd4, 32'h9999_9999, 8'h00, 30); chk_bank("R7 truncated no err");
        // R8: trailing bits ignored
        send(KEYV, 4'd4, 32'hCAFE_F00D, 8'h00, 70); mdl[4] = 32'hCAFE_F00D; chk_bank("R8 trailing bits");

        // R10: readback of registers, live samples and unmapped selector
        readback(4'd0, mdl[0], 0);
        readback(4'd6, mdl[6], 0);
        readback(4'd7, x_live, 0);
        readback(4'd8, y_live, 0);
        readback(4'd12, 32'h0, 0);
        // R11: request during a frame is ignored
        readback(4'd4, mdl[4], 1);
        repeat (200) @(negedge clk);
        chk("R11 no extra frame", {tx_active, 32'(expq.size())}, 33'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule